// File: doc/BRIEF.md
# Two-Stage Early-Terminating Reed-Solomon Syndrome Calculator

This block computes the 2t syndromes of a received Reed-Solomon codeword over GF(2^8), with t = 8 and a default code length of 255 symbols. Each syndrome Si is the received polynomial evaluated at alpha^i. Every syndrome cell runs Horner's rule: on each accepted symbol it multiplies its running value by its own constant alpha^i and adds the symbol. Received symbols arrive one per cycle, highest index first.

The work is split into two passes. The first pass streams the word once and runs only the cells for S1..St. When those t values are all zero, the block terminates at once. It flags the word as needing no correction, and the upper syndromes are never computed. This happens for error-free words and for some words with more than t errors. When any lower syndrome is nonzero, the block raises a read request and the codeword buffer replays the word, highest index first, to fill S(t+1)..S(2t). Error-free traffic therefore costs one pass instead of two. Every multiplier multiplies a variable by a constant.

The controller has five states. IDLE is left for FIRST on an accepted start. FIRST moves to JUDGE after N accepted symbols. JUDGE moves to DONE when the lower half is zero, and to SECOND when it is not. SECOND moves to DONE after N accepted symbols. DONE is left for FIRST on an accepted start.

Top module: `rs_syn_two_stage`

## Requirements
- R1: After reset, `done`, `no_err` and `rd_en` are 0 and every syndrome field is zero.
- R2: In the first pass, each accepted symbol updates S1..St as S <- S*alpha^i + sym. Symbols are taken highest index first, so after N accepted symbols Si = R(alpha^i). The field polynomial is x^8+x^4+x^3+x^2+1 and alpha = 0x02.
- R3: The cycle after the N-th first-pass symbol is accepted is the judge cycle, with `done` = 0 and `rd_en` = 0. If S1..St are all zero, the next cycle shows `done` = 1 and `no_err` = 1, and `rd_en` is never raised. The upper syndromes then read zero.
- R4: If any of S1..St is nonzero, `rd_en` rises in the cycle after the judge cycle and stays high until N symbols have been accepted. These symbols update S(t+1)..S(2t) by Horner's rule. `done` = 1 with `no_err` = 0 is seen in the cycle after the last accepted symbol.
- R5: Upper syndromes do not change outside the second pass, and lower syndromes do not change during it.
- R6: `start` is accepted only in IDLE or DONE. It clears all syndromes, `done` and `no_err`, and a symbol presented in the same cycle is not used. A `start` during a pass or during the judge cycle has no effect.
- R7: Cycles with `in_valid` = 0 leave all syndromes unchanged and are not counted.
- R8: `done`, `no_err` and the syndrome outputs hold their values until the next accepted `start`.
- R9: Syndrome Si occupies `syn[8*i-1 : 8*(i-1)]`, for i = 1..2t.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new word (taken in IDLE or DONE only) |
| in_valid | input | 1 | `in_sym` carries a received symbol this cycle |
| in_sym | input | 8 | Received symbol, highest index first |
| rd_en | output | 1 | Request to replay the stored word for the second pass |
| syn | output | 128 | Syndromes S1..S16, S1 in the low byte |
| no_err | output | 1 | With `done`: lower half all zero, decoding can stop |
| done | output | 1 | Syndrome set complete; held until next start |

## Verification
A new `start` can arrive in the same cycle as an accepted data symbol. This happens with the final symbol of the second pass, with a symbol in the middle of the first pass, and with a stray symbol in the start cycle itself. The bench drives each of these overlaps. A start taken during a pass must change nothing: the syndromes must match a software Horner model of the stored word alone, and `done` must appear in the expected cycle. A start taken in DONE must clear the outputs and must not absorb the symbol presented with it.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
    localparam int unsigned GF_M = 8;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_JUDGE,
        ST_SECOND,
        ST_DONE
    } syn_state_e;

    // GF(2^m) product, LSB-first shift-and-add with reduction by poly
    function automatic gf_t gf_mul(input gf_t a, input gf_t b, input logic [GF_M:0] poly);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[GF_M-1]) sh = (sh << 1) ^ poly[GF_M-1:0];
            else            sh = sh << 1;
        end
        return acc;
    endfunction

    // alpha^k with alpha = x
    function automatic gf_t gf_alpha_pow(input int unsigned k, input logic [GF_M:0] poly);
        gf_t r;
        r = gf_t'(1);
        for (int unsigned i = 0; i < k; i++) begin
            r = gf_mul(r, gf_t'(2), poly);
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
    import rs_syn_pkg::*;
#(
    parameter int unsigned     POWER   = 1,
    parameter logic [GF_M:0]   GF_POLY = 9'h11D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  gf_t  sym,
    output gf_t  acc
);
    localparam gf_t ROOT = gf_alpha_pow(POWER, GF_POLY);

    gf_t acc_q;
    gf_t scaled;

    // constant-by-variable multiply: folds to an XOR network
    always_comb begin
        scaled = gf_mul(acc_q, ROOT, GF_POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= scaled ^ sym;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/rs_syn_bank.sv
module rs_syn_bank
    import rs_syn_pkg::*;
#(
    parameter int unsigned   T_CORR  = 8,
    parameter logic [GF_M:0] GF_POLY = 9'h11D
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en_lo,
    input  logic                       en_hi,
    input  gf_t                        sym,
    output logic [2*T_CORR*GF_M-1:0]   syn,
    output logic                       lo_zero
);
    localparam int unsigned NUM_SYN = 2 * T_CORR;
    localparam int unsigned HALF_W  = T_CORR * GF_M;

    for (genvar g = 0; g < NUM_SYN; g++) begin : g_cell
        localparam bit UPPER = (g >= T_CORR);
        gf_t cell_out;
        logic cell_en;
        if (UPPER) begin : g_hi
            assign cell_en = en_hi;
        end else begin : g_lo
            assign cell_en = en_lo;
        end
        rs_syn_cell #(
            .POWER   (g + 1),
            .GF_POLY (GF_POLY)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (cell_en),
            .sym   (sym),
            .acc   (cell_out)
        );
        assign syn[g*GF_M +: GF_M] = cell_out;
    end

    assign lo_zero = ~|syn[HALF_W-1:0];
endmodule

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl
    import rs_syn_pkg::*;
#(
    parameter int unsigned N_SYM = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic lo_zero,
    output logic clr,
    output logic en_lo,
    output logic en_hi,
    output logic rd_en,
    output logic done,
    output logic no_err
);
    localparam int unsigned CNT_W = (N_SYM > 1) ? $clog2(N_SYM) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_SYM - 1);

    syn_state_e       state_q;
    syn_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             clean_q;
    logic             take_start;
    logic             last_sym;
    logic             streaming;

    assign take_start = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign streaming  = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign last_sym   = in_valid && (cnt_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_start) state_d = ST_FIRST;
            ST_FIRST:  if (last_sym)   state_d = ST_JUDGE;
            ST_JUDGE:  state_d = lo_zero ? ST_DONE : ST_SECOND;
            ST_SECOND: if (last_sym)   state_d = ST_DONE;
            ST_DONE:   if (take_start) state_d = ST_FIRST;
        endcase
    end

    // symbol counter and judge verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_q <= 1'b0;
        end else begin
            if (take_start) begin
                cnt_q   <= '0;
                clean_q <= 1'b0;
            end else if (streaming && in_valid) begin
                cnt_q <= last_sym ? '0 : cnt_q + 1'b1;
            end
            if (state_q == ST_JUDGE) clean_q <= lo_zero;
        end
    end

    // outputs
    always_comb begin
        clr    = take_start;
        en_lo  = 1'b0;
        en_hi  = 1'b0;
        rd_en  = 1'b0;
        done   = 1'b0;
        no_err = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FIRST:  en_lo = in_valid;
            ST_JUDGE:  ;
            ST_SECOND: begin
                rd_en = 1'b1;
                en_hi = in_valid;
            end
            ST_DONE: begin
                done   = 1'b1;
                no_err = clean_q;
            end
        endcase
    end
endmodule

// File: rtl/rs_syn_two_stage.sv
module rs_syn_two_stage
    import rs_syn_pkg::*;
#(
    parameter int unsigned   N_SYM   = 255,
    parameter int unsigned   T_CORR  = 8,
    parameter logic [GF_M:0] GF_POLY = 9'h11D
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_valid,
    input  logic [GF_M-1:0]          in_sym,
    output logic                     rd_en,
    output logic [2*T_CORR*GF_M-1:0] syn,
    output logic                     no_err,
    output logic                     done
);
    logic clr;
    logic en_lo;
    logic en_hi;
    logic lo_zero;

    rs_syn_ctrl #(
        .N_SYM (N_SYM)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .lo_zero  (lo_zero),
        .clr      (clr),
        .en_lo    (en_lo),
        .en_hi    (en_hi),
        .rd_en    (rd_en),
        .done     (done),
        .no_err   (no_err)
    );

    rs_syn_bank #(
        .T_CORR  (T_CORR),
        .GF_POLY (GF_POLY)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en_lo   (en_lo),
        .en_hi   (en_hi),
        .sym     (in_sym),
        .syn     (syn),
        .lo_zero (lo_zero)
    );
endmodule

// File: rtl/rs_syn_two_stage_chk.sv
module rs_syn_two_stage_chk #(
    parameter int unsigned T_CORR = 8,
    parameter int unsigned SYM_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      in_valid,
    input logic                      rd_en,
    input logic [2*T_CORR*SYM_W-1:0] syn,
    input logic                      no_err,
    input logic                      done
);
    localparam int unsigned HALF_W = T_CORR * SYM_W;
    localparam int unsigned FULL_W = 2 * HALF_W;

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> (!done && !no_err && !rd_en));

    p_no_err_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        no_err |-> done);

    p_clean_lower_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        no_err |-> (syn[HALF_W-1:0] == '0));

    p_clean_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        no_err |-> (syn[FULL_W-1:HALF_W] == '0));

    p_replay_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !done);

    p_lower_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> $stable(syn[HALF_W-1:0]));

    p_upper_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !start) |=> $stable(syn[FULL_W-1:HALF_W]));

    p_stall_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !start) |=> $stable(syn));

    p_done_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(no_err) && $stable(syn)));
endmodule

bind rs_syn_two_stage rs_syn_two_stage_chk #(
    .T_CORR (T_CORR),
    .SYM_W  (rs_syn_pkg::GF_M)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .rd_en    (rd_en),
    .syn      (syn),
    .no_err   (no_err),
    .done     (done)
);

// File: tb/tb_rs_syn_two_stage.sv
`timescale 1ns/1ps
module tb_rs_syn_two_stage;
    localparam int N   = 255;
    localparam int T   = 8;
    localparam int NS  = 2 * T;
    localparam int SW  = NS * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_sym = 8'h00;
    logic          rd_en;
    logic [SW-1:0] syn;
    logic          no_err;
    logic          done;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] word [N];
    logic [7:0] gpoly [NS+1];
    logic [7:0] exp_s [1:NS];
    int unsigned lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    rs_syn_two_stage dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_sym(in_sym), .rd_en(rd_en), .syn(syn), .no_err(no_err), .done(done)
    );

    // ---------------- reference arithmetic (MSB-first) ----------------
    function automatic logic [7:0] xt(input logic [7:0] x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    endfunction

    function automatic logic [7:0] mmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            r = xt(r);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [7:0] apow(input int k);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < k; i++) r = xt(r);
        return r;
    endfunction

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    task automatic model();
        for (int i = 1; i <= NS; i++) begin
            logic [7:0] s;
            logic [7:0] a;
            a = apow(i);
            s = 8'h00;
            for (int k = N - 1; k >= 0; k--) s = mmul(s, a) ^ word[k];
            exp_s[i] = s;
        end
    endtask

    // ---------------- word construction ----------------
    task automatic build_gen(input int roots);
        for (int k = 0; k <= NS; k++) gpoly[k] = 8'h00;
        gpoly[0] = 8'h01;
        for (int i = 1; i <= roots; i++) begin
            logic [7:0] a;
            a = apow(i);
            for (int k = NS; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ mmul(gpoly[k], a);
            gpoly[0] = mmul(gpoly[0], a);
        end
    endtask

    task automatic clear_word();
        for (int k = 0; k < N; k++) word[k] = 8'h00;
    endtask

    task automatic make_codeword();
        clear_word();
        build_gen(NS);
        for (int q = 0; q < 6; q++) begin
            int j;
            logic [7:0] m;
            j = int'(rnd() % (N - NS));
            m = 8'(rnd() % 255) + 8'h01;
            for (int k = 0; k <= NS; k++) word[j+k] = word[j+k] ^ mmul(m, gpoly[k]);
        end
    endtask

    task automatic add_errors(input int cnt);
        int base;
        base = int'(rnd() % N);
        for (int q = 0; q < cnt; q++) begin
            int p;
            p = (base + q * 37) % N;
            word[p] = word[p] ^ (8'(rnd() % 255) + 8'h01);
        end
    endtask

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [SW-1:0] act, input logic [SW-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [SW-1:0] exp_vec(input bit clean);
        logic [SW-1:0] v;
        v = '0;
        for (int i = 1; i <= NS; i++) begin
            if (i <= T || !clean) v[8*i-1 -: 8] = exp_s[i];   // R9 layout
        end
        return v;
    endfunction

    // inj_pass/inj_idx: a start pulse riding on that symbol (R6)
    task automatic run_word(input string req, input bit stall, input bit junk,
                            input int inj_pass, input int inj_idx);
        bit clean;
        model();
        clean = 1'b1;
        for (int i = 1; i <= T; i++) if (exp_s[i] != 8'h00) clean = 1'b0;

        @(negedge clk);
        start = 1'b1;
        in_valid = junk;
        in_sym = 8'h5A;
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b0;
        chk(syn == '0 && !done && !no_err, "R6", "clear on start", SW'(syn), '0);

        for (int k = 0; k < N; k++) begin
            if (stall && (k % 5 == 2)) begin
                in_valid = 1'b0;
                in_sym = 8'hA5;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sym = word[N-1-k];
            start = (inj_pass == 1 && inj_idx == k);
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        chk(!done && !rd_en, "R3", "judge cycle quiet", SW'({done, rd_en}), '0);
        @(negedge clk);

        if (clean) begin
            chk(done && no_err && !rd_en, "R3", "terminate flags",
                SW'({done, no_err, rd_en}), SW'(3'b110));
        end else begin
            chk(rd_en && !done, "R4", "replay request", SW'({rd_en, done}), SW'(2'b10));
            for (int k = 0; k < N; k++) begin
                if (stall && (k % 7 == 4)) begin
                    in_valid = 1'b0;
                    in_sym = 8'h3C;
                    @(negedge clk);
                end
                if (!rd_en) begin
                    chk(1'b0, "R4", "rd_en dropped early", SW'(k), SW'(N));
                    break;
                end
                in_valid = 1'b1;
                in_sym = word[N-1-k];
                start = (inj_pass == 2 && inj_idx == k);
                @(negedge clk);
                start = 1'b0;
            end
            in_valid = 1'b0;
            chk(done && !no_err && !rd_en, "R4", "second pass end flags",
                SW'({done, no_err, rd_en}), SW'(3'b100));
        end
        chk(syn == exp_vec(clean), req, "syndromes", syn, exp_vec(clean));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(!done && !no_err && !rd_en && syn == '0, "R1", "reset state",
            SW'({syn == '0, done, no_err, rd_en}), SW'(4'b1000));
    endtask

    task automatic t_zero_word();
        clear_word();
        run_word("R3", 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_codeword();
        make_codeword();
        run_word("R3", 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_errors(input int cnt);
        make_codeword();
        add_errors(cnt);
        run_word("R2/R4", 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_hidden();
        // low-half roots only: S1..S8 vanish, upper half does not
        clear_word();
        build_gen(T);
        for (int k = 0; k <= T; k++) word[40+k] = gpoly[k];
        run_word("R3", 1'b0, 1'b0, 0, 0);
        chk(no_err == 1'b1, "R3", "hidden word terminates", SW'(no_err), SW'(1));
    endtask

    task automatic t_layout();
        clear_word();
        word[1] = 8'h01;
        run_word("R9", 1'b0, 1'b0, 0, 0);
        chk(syn[7:0] == 8'h02 && syn[15:8] == 8'h04 && syn[127:120] == apow(16),
            "R9", "field positions", syn, SW'({apow(16), 104'h0, 8'h04, 8'h02}));
    endtask

    task automatic t_stalls();
        make_codeword();
        add_errors(5);
        run_word("R7", 1'b1, 1'b0, 0, 0);
    endtask

    task automatic t_start_overlap();
        make_codeword();
        add_errors(3);
        run_word("R6", 1'b0, 1'b1, 1, 100);
        make_codeword();
        add_errors(7);
        run_word("R6", 1'b0, 1'b0, 2, N - 1);
    endtask

    task automatic t_hold();
        logic [SW-1:0] snap;
        logic          ne;
        make_codeword();
        add_errors(2);
        run_word("R4", 1'b0, 1'b0, 0, 0);
        snap = syn;
        ne = no_err;
        for (int c = 0; c < 30; c++) begin
            in_valid = c[0];
            in_sym = 8'(c * 13);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(done && no_err == ne && syn == snap, "R8", "outputs held", syn, snap);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_word();
        t_codeword();
        for (int e = 1; e <= T; e++) t_errors(e);
        t_errors(12);
        t_hidden();
        t_layout();
        t_stalls();
        t_start_overlap();
        t_hold();
        t_codeword();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule